// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Processor Core

This block is a small processor built around one 16-bit accumulator. It retires one instruction per clock while `run` is high. Each instruction word names an operation and an 8-bit field. Depending on the operation, that field is an immediate value, a data-memory address, an I/O port number or a branch offset. The core holds its own instruction memory and word-addressed data memory. A separate load port fills both memories while the core is idle, and a peek port reads data memory back so that results can be inspected.

Two timing quirks are part of the programming model. First, conditional branches and the jump-and-link target use the accumulator as it stood after the instruction two places back in the executed stream. Second, every instruction reloads an address register from the data word its low field points at, and only the next instruction can use that value for indirect access. The core stops for good when it meets an undefined encoding, or when the program counter reaches the programmed size limit.

Top module: `acc_core`

## Requirements
- R1: After reset, the program counter is 1, the accumulator and address register are 0, and both `done` and `illegal` are low. The word at address 0 is never executed.
- R2: When instruction bit 8 is 1, the operand is bits 7:0 sign-extended to 16 bits. When bit 8 is 0, the operand is the data word addressed by bits 7:0.
- R3: Bits 15:9 select the operation. 0x00 is no-op, 0x04 add, 0x06 subtract, 0x08 logical shift right by one, 0x10 load, 0x11 AND, 0x12 OR and 0x13 XOR. Each of these advances the PC by one, and the accumulator wraps at 16 bits.
- R4: Bits 15:9 = 0x14 (load-high) keeps the accumulator's low byte and puts the operand's low byte in the high byte.
- R5: Bits 15:9 = 0x18 writes the accumulator to the data word addressed by bits 7:0.
- R6: Bits 15:9 = 0x1C gives a one-cycle `io_wr` with `io_addr` equal to bits 7:0 and `io_wdata` equal to the accumulator. Bits 15:9 = 0x1E gives a one-cycle `io_rd`, and `io_rdata` from that same cycle becomes the accumulator.
- R7: After every executed instruction, the address register takes the data word at bits 7:0. A write by the same instruction to that word is seen. Bits 15:9 = 0x28 does only this. 0x30 loads the data word at (address register + bits 7:0), and 0x38 stores the accumulator there, with the sum wrapping at the data memory size.
- R8: Bits 15:8 of 0x48 to 0x4C branch to PC plus the sign-extended bits 7:0. The conditions are: 0x48 always, 0x49 if zero, 0x4A if nonzero, 0x4B if bit 15 is clear, 0x4C if bit 15 is set. The condition is tested on the accumulator value from two executed instructions earlier.
- R9: Bits 15:9 = 0x20 writes PC+1 to the data word at bits 7:0 and jumps to the accumulator value from two executed instructions earlier.
- R10: Any other encoding sets a sticky `illegal` flag, changes no state and halts the core.
- R11: When the PC is not below `prog_size`, `done` rises and the core halts with no state change.
- R12: While `run` is low, no instruction executes. The load port writes instruction memory when `ld_dm` is 0 and data memory when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one instruction per cycle while high |
| prog_size | input | IM_AW+1 | PC limit; reaching it halts with done |
| ld_we | input | 1 | Load-port write enable |
| ld_dm | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | max(IM_AW,DM_AW) | Load-port word address |
| ld_data | input | 16 | Load-port data |
| peek_addr | input | DM_AW | Data-memory read-back address |
| peek_data | output | 16 | Data-memory read-back word |
| io_addr | output | 8 | I/O port number |
| io_wdata | output | 16 | I/O write data |
| io_wr | output | 1 | I/O write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_rdata | input | 16 | I/O read data, sampled with io_rd |
| pc | output | IM_AW | Program counter |
| acc | output | 16 | Accumulator |
| done | output | 1 | Halted at the program-size limit |
| illegal | output | 1 | Halted on an undefined encoding |

## Verification
The properties assume that `io_rdata` is valid in any cycle where `io_rd` is high. The bench drives it as a pure function of `io_addr`, so that assumption always holds. The properties also assume that the load port is idle while `run` is high. The bench loads each program and its data with `run` low, and only afterwards raises `run` for a bounded number of cycles. Random programs mostly use branch offsets near zero and only occasionally use jump-and-link, so runs stay inside the loaded program and most of them reach the size limit.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [4:0] {
      OP_NOP, OP_ADD, OP_SUB, OP_SHR, OP_LD, OP_AND, OP_OR, OP_XOR,
      OP_LDH, OP_ST, OP_OUT, OP_IN, OP_JAL, OP_LDAR, OP_LDI, OP_STI,
      OP_BR, OP_ILL
   } op_e;

   typedef enum logic [2:0] {
      BC_ALWAYS = 3'd0,
      BC_ZERO   = 3'd1,
      BC_NZERO  = 3'd2,
      BC_POS    = 3'd3,
      BC_NEG    = 3'd4,
      BC_R5     = 3'd5,
      BC_R6     = 3'd6,
      BC_R7     = 3'd7
   } brc_e;

   typedef struct packed {
      op_e        op;
      brc_e       cond;
      logic       imm;
      logic [7:0] low8;
   } dec_t;

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
   parameter int AW  = 10,
   parameter int DW  = 16,
   parameter int NRD = 1
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [AW-1:0]            waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [NRD-1:0][AW-1:0]   raddr,
   output logic [NRD-1:0][DW-1:0]   rdata
);
   localparam int DEPTH = 1 << AW;

   if (NRD < 1) begin : g_bad_nrd
      $error("acc_ram: NRD must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar i = 0; i < NRD; i++) begin : g_rd
      assign rdata[i] = mem[raddr[i]];
   end
endmodule

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
(
   input  logic [WORD_W-1:0] instr,
   output dec_t              dec
);
   always_comb begin
      dec.low8 = instr[7:0];
      dec.imm  = instr[8];
      dec.cond = brc_e'(instr[10:8]);
      unique case (instr[15:9])
         7'h00:   dec.op = OP_NOP;
         7'h04:   dec.op = OP_ADD;
         7'h06:   dec.op = OP_SUB;
         7'h08:   dec.op = OP_SHR;
         7'h10:   dec.op = OP_LD;
         7'h11:   dec.op = OP_AND;
         7'h12:   dec.op = OP_OR;
         7'h13:   dec.op = OP_XOR;
         7'h14:   dec.op = OP_LDH;
         7'h18:   dec.op = OP_ST;
         7'h1C:   dec.op = OP_OUT;
         7'h1E:   dec.op = OP_IN;
         7'h20:   dec.op = OP_JAL;
         7'h28:   dec.op = OP_LDAR;
         7'h30:   dec.op = OP_LDI;
         7'h38:   dec.op = OP_STI;
         default: dec.op = (instr[15:8] >= 8'h48 && instr[15:8] <= 8'h4C) ? OP_BR : OP_ILL;
      endcase
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
(
   input  op_e               op,
   input  logic [WORD_W-1:0] acc,
   input  logic [WORD_W-1:0] opnd,
   input  logic [WORD_W-1:0] io_in,
   input  logic [WORD_W-1:0] ind_rd,
   output logic [WORD_W-1:0] res
);
   always_comb begin
      unique case (op)
         OP_ADD:  res = acc + opnd;
         OP_SUB:  res = acc - opnd;
         OP_SHR:  res = {1'b0, acc[WORD_W-1:1]};
         OP_LD:   res = opnd;
         OP_AND:  res = acc & opnd;
         OP_OR:   res = acc | opnd;
         OP_XOR:  res = acc ^ opnd;
         OP_LDH:  res = {opnd[7:0], acc[7:0]};
         OP_IN:   res = io_in;
         OP_LDI:  res = ind_rd;
         default: res = acc;
      endcase
   end
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter  int IM_AW = 10,
   parameter  int DM_AW = 10,
   localparam int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW,
   localparam int W     = WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [IM_AW:0]   prog_size,
   input  logic             ld_we,
   input  logic             ld_dm,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [W-1:0]     ld_data,
   input  logic [DM_AW-1:0] peek_addr,
   output logic [W-1:0]     peek_data,
   output logic [7:0]       io_addr,
   output logic [W-1:0]     io_wdata,
   output logic             io_wr,
   output logic             io_rd,
   input  logic [W-1:0]     io_rdata,
   output logic [IM_AW-1:0] pc,
   output logic [W-1:0]     acc,
   output logic             done,
   output logic             illegal
);
   if (IM_AW < 2 || IM_AW > 15) begin : g_bad_im
      $error("acc_core: IM_AW must lie in 2..15");
   end
   if (DM_AW < 8 || DM_AW > 16) begin : g_bad_dm
      $error("acc_core: DM_AW must lie in 8..16");
   end

   logic [IM_AW-1:0] pc_q, pc_d;
   logic [W-1:0]     acc_q, acc_d, prev_q;
   logic [DM_AW-1:0] ar_q, ar_d;
   logic             done_q, ill_q;

   // ---------------- instruction fetch and decode ----------------
   logic [W-1:0] instr;
   logic [0:0][IM_AW-1:0] im_ra;
   logic [0:0][W-1:0]     im_rd;
   assign im_ra[0] = pc_q;
   assign instr    = im_rd[0];

   acc_ram #(.AW(IM_AW), .DW(W), .NRD(1)) u_imem (
      .clk   (clk),
      .we    (ld_we & ~ld_dm),
      .waddr (ld_addr[IM_AW-1:0]),
      .wdata (ld_data),
      .raddr (im_ra),
      .rdata (im_rd)
   );

   dec_t dec;
   acc_decode u_dec (.instr(instr), .dec(dec));

   // ---------------- step qualification ----------------
   logic live, end_hit, exec, trap;
   assign end_hit = ({1'b0, pc_q} >= prog_size);
   assign live    = run & ~done_q & ~ill_q;
   assign exec    = live & ~end_hit & (dec.op != OP_ILL);
   assign trap    = live & ~end_hit & (dec.op == OP_ILL);

   // ---------------- data memory addressing ----------------
   logic [DM_AW-1:0] low_addr, ind_addr;
   if (DM_AW == 8) begin : g_la_exact
      assign low_addr = dec.low8;
   end else begin : g_la_ext
      assign low_addr = {{(DM_AW-8){1'b0}}, dec.low8};
   end
   assign ind_addr = ar_q + low_addr;

   logic             core_we, dm_we;
   logic [DM_AW-1:0] core_wa, dm_wa;
   logic [W-1:0]     core_wd, dm_wd;
   logic [2:0][DM_AW-1:0] dm_ra;
   logic [2:0][W-1:0]     dm_rd;

   always_comb begin
      core_we = 1'b0;
      core_wa = low_addr;
      core_wd = acc_q;
      if (exec) begin
         unique case (dec.op)
            OP_ST:   core_we = 1'b1;
            OP_STI:  begin core_we = 1'b1; core_wa = ind_addr; end
            OP_JAL:  begin core_we = 1'b1; core_wd = W'(pc_q) + W'(1); end
            default: core_we = 1'b0;
         endcase
      end
   end

   assign dm_we = core_we | (ld_we & ld_dm);
   assign dm_wa = core_we ? core_wa : ld_addr[DM_AW-1:0];
   assign dm_wd = core_we ? core_wd : ld_data;
   assign dm_ra[0] = low_addr;
   assign dm_ra[1] = ind_addr;
   assign dm_ra[2] = peek_addr;

   acc_ram #(.AW(DM_AW), .DW(W), .NRD(3)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_wa),
      .wdata (dm_wd),
      .raddr (dm_ra),
      .rdata (dm_rd)
   );

   // ---------------- operand and accumulator ----------------
   logic [W-1:0] operand;
   assign operand = dec.imm ? {{(W-8){dec.low8[7]}}, dec.low8} : dm_rd[0];

   acc_alu u_alu (
      .op     (dec.op),
      .acc    (acc_q),
      .opnd   (operand),
      .io_in  (io_rdata),
      .ind_rd (dm_rd[1]),
      .res    (acc_d)
   );

   // address register sees a same-instruction write to its source word
   assign ar_d = (core_we && core_wa == low_addr) ? core_wd[DM_AW-1:0]
                                                  : dm_rd[0][DM_AW-1:0];

   // ---------------- next PC ----------------
   logic br_take;
   always_comb begin
      unique case (dec.cond)
         BC_ALWAYS: br_take = 1'b1;
         BC_ZERO:   br_take = (prev_q == '0);
         BC_NZERO:  br_take = (prev_q != '0);
         BC_POS:    br_take = ~prev_q[W-1];
         BC_NEG:    br_take = prev_q[W-1];
         default:   br_take = 1'b0;
      endcase
   end

   logic [IM_AW-1:0] br_off;
   assign br_off = IM_AW'({{(W-8){dec.low8[7]}}, dec.low8});

   always_comb begin
      pc_d = pc_q + IM_AW'(1);
      if (dec.op == OP_JAL)             pc_d = prev_q[IM_AW-1:0];
      else if (dec.op == OP_BR && br_take) pc_d = pc_q + br_off;
   end

   // ---------------- state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= IM_AW'(1);
         acc_q  <= '0;
         prev_q <= '0;
         ar_q   <= '0;
         done_q <= 1'b0;
         ill_q  <= 1'b0;
      end else begin
         if (live && end_hit) done_q <= 1'b1;
         if (trap)            ill_q  <= 1'b1;
         if (exec) begin
            pc_q   <= pc_d;
            acc_q  <= acc_d;
            prev_q <= acc_q;
            ar_q   <= ar_d;
         end
      end
   end

   assign pc        = pc_q;
   assign acc       = acc_q;
   assign done      = done_q;
   assign illegal   = ill_q;
   assign peek_data = dm_rd[2];
   assign io_addr   = dec.low8;
   assign io_wdata  = acc_q;
   assign io_wr     = exec & (dec.op == OP_OUT);
   assign io_rd     = exec & (dec.op == OP_IN);

   // ---------------- assertions ----------------
   assert_seq_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && dec.op inside {OP_NOP, OP_ADD, OP_SUB, OP_SHR, OP_LD, OP_AND, OP_OR, OP_XOR})
      |=> pc_q == $past(pc_q) + IM_AW'(1));

   assert_in_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd |=> acc_q == $past(io_rdata));

   assert_jal_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && dec.op == OP_JAL) |=> pc_q == $past(prev_q[IM_AW-1:0]));

   assert_ill_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ill_q |=> ($stable(pc_q) && $stable(acc_q)));

   assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> ($stable(pc_q) && $stable(acc_q)));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(pc_q) && $stable(acc_q)));

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
   localparam int IM_AW = 10;
   localparam int DM_AW = 10;
   localparam int IMN = 1 << IM_AW;
   localparam int DMN = 1 << DM_AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, run, ld_we, ld_dm, io_wr, io_rd, done, illegal;
   logic [IM_AW:0] prog_size;
   logic [IM_AW-1:0] ld_addr, pc;
   logic [DM_AW-1:0] peek_addr;
   logic [15:0] ld_data, peek_data, io_wdata, io_rdata, acc;
   logic [7:0] io_addr;

   function automatic logic [15:0] iofn(input logic [7:0] a);
      return {a ^ 8'h3C, ~a};
   endfunction
   assign io_rdata = iofn(io_addr);

   acc_core #(.IM_AW(IM_AW), .DM_AW(DM_AW)) dut (
      .clk(clk), .rst_n(rst_n), .run(run), .prog_size(prog_size),
      .ld_we(ld_we), .ld_dm(ld_dm), .ld_addr(ld_addr), .ld_data(ld_data),
      .peek_addr(peek_addr), .peek_data(peek_data),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
      .io_rdata(io_rdata), .pc(pc), .acc(acc), .done(done), .illegal(illegal)
   );

   int checks = 0, failures = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [15:0] m_im [IMN];
   logic [15:0] m_dm [DMN];
   int          m_pc, m_size;
   logic [15:0] m_acc, m_prev, m_ar;
   bit          m_done, m_ill;
   logic [7:0]  last_wr_addr;
   logic [15:0] last_wr_data;

   function automatic string req_of(input logic [15:0] ins);
      case (ins[15:9])
         7'h14: return "R4";
         7'h18: return "R5";
         7'h1C, 7'h1E: return "R6";
         7'h28, 7'h30, 7'h38: return "R7";
         7'h20: return "R9";
         7'h00, 7'h04, 7'h06, 7'h08, 7'h10, 7'h11, 7'h12, 7'h13: return "R3";
         default: return (ins[15:8] >= 8'h48 && ins[15:8] <= 8'h4C) ? "R8" : "R10";
      endcase
   endfunction

   task automatic model_reset();
      m_pc = 1; m_acc = 0; m_prev = 0; m_ar = 0; m_done = 0; m_ill = 0;
   endtask

   task automatic model_step(output bit e_wr, output bit e_rd,
                             output logic [15:0] e_wd, output string tag);
      logic [15:0] ins, opnd, nacc, wd;
      logic [7:0]  l8;
      int nxt, ia, wa;
      bit wen, tk;
      e_wr = 0; e_rd = 0; e_wd = 0; tag = "R11";
      if (m_done || m_ill) return;
      if (m_pc >= m_size) begin m_done = 1; return; end
      ins  = m_im[m_pc];
      tag  = req_of(ins);
      l8   = ins[7:0];
      opnd = ins[8] ? {{8{l8[7]}}, l8} : m_dm[l8];
      nxt  = (m_pc + 1) % IMN;
      ia   = (int'(m_ar) + int'(l8)) % DMN;
      nacc = m_acc; wen = 0; wa = l8; wd = m_acc;
      case (ins[15:9])
         7'h00: ;
         7'h04: nacc = m_acc + opnd;
         7'h06: nacc = m_acc - opnd;
         7'h08: nacc = m_acc >> 1;
         7'h10: nacc = opnd;
         7'h11: nacc = m_acc & opnd;
         7'h12: nacc = m_acc | opnd;
         7'h13: nacc = m_acc ^ opnd;
         7'h14: nacc = {opnd[7:0], m_acc[7:0]};
         7'h18: wen = 1;
         7'h1C: begin e_wr = 1; e_wd = m_acc; end
         7'h1E: begin e_rd = 1; nacc = iofn(l8); end
         7'h20: begin wen = 1; wd = 16'(m_pc + 1); nxt = int'(m_prev) % IMN; end
         7'h28: ;
         7'h30: nacc = m_dm[ia];
         7'h38: begin wen = 1; wa = ia; end
         default: begin
            if (ins[15:8] >= 8'h48 && ins[15:8] <= 8'h4C) begin
               case (ins[10:8])
                  3'd0: tk = 1;
                  3'd1: tk = (m_prev == 0);
                  3'd2: tk = (m_prev != 0);
                  3'd3: tk = !m_prev[15];
                  default: tk = m_prev[15];
               endcase
               if (tk) nxt = (m_pc + int'($signed(l8)) + IMN) % IMN;
            end else begin
               m_ill = 1;
               return;
            end
         end
      endcase
      if (wen) m_dm[wa] = wd;
      m_ar   = m_dm[l8];
      m_prev = m_acc;
      m_acc  = nacc;
      m_pc   = nxt;
   endtask

   // ---------------- drivers ----------------
   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; run = 0; ld_we = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   task automatic load(input bit to_dm, input int addr, input logic [15:0] data);
      ld_we = 1; ld_dm = to_dm; ld_addr = IM_AW'(addr); ld_data = data;
      if (to_dm) m_dm[addr] = data; else m_im[addr] = data;
      @(negedge clk);
      ld_we = 0;
   endtask

   task automatic run_prog(input int steps);
      bit ew, er;
      logic [15:0] ewd;
      string tag;
      prog_size = (IM_AW+1)'(m_size);
      run = 1;
      for (int i = 0; i < steps; i++) begin
         #1;
         model_step(ew, er, ewd, tag);
         chk("R6", "io_wr", io_wr, ew);
         chk("R6", "io_rd", io_rd, er);
         if (ew) begin
            chk("R6", "io_wdata", io_wdata, ewd);
            last_wr_addr = io_addr; last_wr_data = io_wdata;
         end
         @(negedge clk);
         chk(tag, "pc", pc, m_pc);
         chk(tag, "acc", acc, m_acc);
         chk("R11", "done", done, m_done);
         chk("R10", "illegal", illegal, m_ill);
      end
      run = 0;
      @(negedge clk);
   endtask

   task automatic compare_dm(input string req);
      for (int a = 0; a < DMN; a++) begin
         peek_addr = DM_AW'(a);
         #1;
         chk(req, "dm word", peek_data, m_dm[a]);
      end
   endtask

   task automatic fill_dm();
      for (int a = 0; a < DMN; a++) load(1, a, 16'($urandom));
   endtask

   function automatic logic [15:0] gen_instr();
      int r = $urandom % 100;
      logic [7:0] l8 = 8'($urandom);
      logic b8 = 1'($urandom);
      logic [7:0] alu_top [8] = '{8'h08, 8'h0C, 8'h10, 8'h20, 8'h22, 8'h24, 8'h26, 8'h28};
      if (r < 40) return {alu_top[$urandom % 8] | {7'd0, b8}, l8};
      if (r < 50) return {8'h30, l8};
      if (r < 55) return {8'h38, l8};
      if (r < 60) return {8'h3C, l8};
      if (r < 65) return {8'h50, l8};
      if (r < 72) return {8'h60 | {7'd0, b8}, l8};
      if (r < 78) return {8'h70 | {7'd0, b8}, l8};
      if (r < 94) return {8'h48 + 8'($urandom % 5), 8'(int'($urandom % 13) - 6)};
      if (r < 97) return {8'h40, l8};
      if (r < 99) return 16'h0000;
      return (r[0]) ? 16'h4D00 : {8'hFE, l8};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_1234);
      rst_n = 0; run = 0; ld_we = 0; ld_dm = 0; ld_addr = 0; ld_data = 0;
      peek_addr = 0; prog_size = 0;
      last_wr_addr = 0; last_wr_data = 0;
      do_reset();

      // R1 reset state, R12 idle hold
      #1;
      chk("R1", "reset pc", pc, 1);
      chk("R1", "reset acc", acc, 0);
      chk("R1", "reset flags", {done, illegal, io_wr, io_rd}, 0);
      repeat (4) @(negedge clk);
      chk("R12", "idle pc", pc, 1);
      chk("R12", "idle acc", acc, 0);

      // ---- directed program 1 ----
      fill_dm();
      load(1, 7, 16'hBEEF); load(1, 16'h40, 16'h0100); load(1, 34, 16'h7777);
      load(0, 0, 16'h2155);
      load(0, 1, 16'h2105);  load(0, 2, 16'h3010);  load(0, 3, 16'h6002);
      load(0, 4, 16'h2912);  load(0, 5, 16'h1000);  load(0, 6, 16'h3807);
      load(0, 7, 16'h0840);  load(0, 8, 16'h0DFE);  load(0, 9, 16'h3041);
      load(0, 10, 16'h3C03); load(0, 11, 16'h3042); load(0, 12, 16'h2100);
      load(0, 13, 16'h2101); load(0, 14, 16'h4902); load(0, 15, 16'h3022);
      load(0, 16, 16'h2114); load(0, 17, 16'h0000); load(0, 18, 16'h4020);
      load(0, 19, 16'hFFFF); load(0, 20, 16'h3021);
      do_reset();
      m_size = 21;
      run_prog(30);
      chk("R11", "d1 final pc", pc, 21);
      chk("R11", "d1 done", done, 1);
      chk("R9", "d1 final acc", acc, 16'd20);
      peek_addr = 10'd16; #1; chk("R7", "store then ar-indirect base", peek_data, 16'd5);
      peek_addr = 10'h41; #1; chk("R2", "mem operand add and imm sub", peek_data, 16'h0A79);
      peek_addr = 10'h42; #1; chk("R6", "in captured", peek_data, 16'h3FFC);
      peek_addr = 10'd32; #1; chk("R9", "link word", peek_data, 16'd19);
      peek_addr = 10'd33; #1; chk("R9", "jump landed", peek_data, 16'd20);
      peek_addr = 10'd34; #1; chk("R8", "delayed zero branch skipped", peek_data, 16'h7777);
      chk("R6", "out port", last_wr_addr, 8'h07);
      chk("R4", "loadh then shr value out", last_wr_data, 16'h0977);
      compare_dm("R5");

      // ---- directed program 2: reset AR, illegal ----
      load(1, 5, 16'h1357);
      load(0, 1, 16'h6005); load(0, 2, 16'hFE00); load(0, 3, 16'h2109);
      do_reset();
      m_size = 4;
      run_prog(6);
      chk("R1", "ar zero after reset", acc, 16'h1357);
      chk("R10", "illegal set", illegal, 1);
      chk("R10", "illegal pc held", pc, 2);
      chk("R10", "no done", done, 0);

      // ---- directed program 3: size limit at start ----
      do_reset();
      m_size = 1;
      run_prog(3);
      chk("R11", "limit done", done, 1);
      chk("R11", "limit pc", pc, 1);
      chk("R11", "limit acc", acc, 0);

      // ---- random programs ----
      for (int p = 0; p < 16; p++) begin
         int sz = 10 + int'($urandom % 50);
         fill_dm();
         for (int a = 0; a < sz; a++) load(0, a, gen_instr());
         do_reset();
         m_size = sz;
         run_prog(120);
         compare_dm("R7");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule